// File: doc/BRIEF.md
# Quadrature Decoder with Modulo Position Counter

This block turns the two signals of an incremental encoder into a signed-direction position count. In the default decoding mode the two inputs are treated as phase signals in quadrature, and every legal edge on either of them moves the counter by one step. In the alternative mode one input acts as a count strobe and the other as a direction level. Both inputs pass through a two-stage synchronizer, an optional per-input inversion and an optional per-input stability filter before they are decoded.

The counter lives inside a window bounded by a programmable low limit and a programmable high limit. A step past either end reloads the counter with the opposite limit, raises a sticky overflow flag and records at which end the wrap happened. A command write reloads the counter with the low limit at any time, and a second command bit clears the overflow flag. All settings are written and read through a small address/data port; position and status are also available as direct outputs.

Top module: `qdec_top`

## Requirements
- R1: After reset the count is 0, direction is 0, overflow and wrap-end flags are 0, the low limit reads 0 and the high limit reads all ones.
- R2: In phase mode (control bit 0 = 0), with A as bit 1 and B as bit 0, each transition along 00→10→11→01→00 adds one to the count and each transition in the reverse order subtracts one.
- R3: In phase mode, a change of both inputs between two successive filtered samples does not change the count or the direction.
- R4: In strobe mode (control bit 0 = 1), each rising edge of the filtered A input adds one when filtered B is high and subtracts one when it is low; falling edges of A and any change on B alone leave the count unchanged.
- R5: Control bit 1 inverts input A and control bit 2 inverts input B before decoding; toggling an inversion bit is seen by the decoder as an edge on that input.
- R6: With the filter of an input enabled (control bit 3 for A, bit 4 for B) and a filter length N > 0 (bits 11:8 for A, bits 15:12 for B), a new level reaches the decoder only after it has held for N consecutive clocks; shorter pulses are discarded.
- R7: With the filter disabled, or enabled with length 0, a one-clock pulse on an input reaches the decoder.
- R8: An up step while the count equals the high limit loads the low limit, sets the overflow flag and sets the wrap-end flag to 1 (top).
- R9: A down step while the count equals the low limit loads the high limit, sets the overflow flag and sets the wrap-end flag to 0 (bottom).
- R10: The direction output is 1 after an up step and 0 after a down step, and holds between steps.
- R11: Writing 1 to bit 0 at address 3 loads the count with the low limit.
- R12: The overflow flag stays set until 1 is written to bit 1 at address 3.
- R13: Reads return the control word (address 0), low limit (1), high limit (2), status {wrap-end, overflow, direction} in bits 2:0 (3) and count (4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_a_i | input | 1 | Encoder input A (phase A or count strobe), asynchronous |
| enc_b_i | input | 1 | Encoder input B (phase B or direction), asynchronous |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wr_data_i | input | CNT_W | Register write data |
| rd_data_o | output | CNT_W | Register read data for addr_i |
| count_o | output | CNT_W | Current position count |
| dir_o | output | 1 | Direction of last step (1 = up) |
| ovf_o | output | 1 | Sticky overflow flag |
| ovf_top_o | output | 1 | End of last wrap (1 = top, 0 = bottom) |

## Verification
A stale previous-sample register in the decoder shows at the ports as a count that moves on a double change or moves the wrong way on the very next edge, three to four clocks after the pin change. A filter counter that fails to restart lets a short pulse reach the count within one filter window, while a wrong wrap condition shows up as a count outside the limits or a missing overflow flag on the step that crosses an end. The bench walks the count across both limits, through the inversion and filter controls and both decoding modes, and compares position and status after every settled stimulus.

// File: rtl/qdec_pkg.sv
package qdec_pkg;

    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] ADR_CTRL  = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_LOW   = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_HIGH  = 3'd2;
    localparam logic [ADDR_W-1:0] ADR_CMD   = 3'd3;
    localparam logic [ADDR_W-1:0] ADR_COUNT = 3'd4;

    // control word bit positions
    localparam int CB_MODE  = 0;
    localparam int CB_INV   = 1;   // A at 1, B at 2
    localparam int CB_FEN   = 3;   // A at 3, B at 4
    localparam int CB_FVAL  = 8;   // A field first, B field after it

    typedef enum logic [1:0] {
        STEP_NONE = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } step_e;

    typedef struct packed {
        logic top;
        logic ovf;
        logic dir;
    } qdec_stat_t;

    // Gray-order step between two {a,b} samples
    function automatic step_e phase_step(input logic [1:0] prev, input logic [1:0] cur);
        step_e s;
        case ({prev, cur})
            4'b00_10, 4'b10_11, 4'b11_01, 4'b01_00: s = STEP_UP;
            4'b00_01, 4'b01_11, 4'b11_10, 4'b10_00: s = STEP_DOWN;
            default:                                 s = STEP_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/qdec_filter.sv
module qdec_filter #(
    parameter int FILT_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pin_i,
    input  logic              inv_i,
    input  logic              en_i,
    input  logic [FILT_W-1:0] len_i,
    output logic              lvl_o
);
    localparam logic [FILT_W-1:0] ONE = FILT_W'(1);

    logic [1:0]        sync_q;
    logic [FILT_W-1:0] run_q;
    logic              smp;
    logic              bypass;

    assign smp    = sync_q[1] ^ inv_i;
    assign bypass = !en_i || (len_i == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            run_q  <= '0;
            lvl_o  <= 1'b0;
        end else begin
            sync_q <= {sync_q[0], pin_i};
            if (smp == lvl_o) begin
                run_q <= '0;
            end else if (bypass || run_q == (len_i - ONE)) begin
                lvl_o <= smp;
                run_q <= '0;
            end else begin
                run_q <= run_q + ONE;
            end
        end
    end
endmodule

// File: rtl/qdec_decode.sv
module qdec_decode
    import qdec_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  strobe_mode_i,
    input  logic  a_i,
    input  logic  b_i,
    output step_e step_o
);
    logic [1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 2'b00;
        else     prev_q <= {a_i, b_i};
    end

    always_comb begin
        if (strobe_mode_i) begin
            if (a_i && !prev_q[1]) step_o = b_i ? STEP_UP : STEP_DOWN;
            else                   step_o = STEP_NONE;
        end else begin
            step_o = phase_step(prev_q, {a_i, b_i});
        end
    end
endmodule

// File: rtl/qdec_counter.sv
module qdec_counter
    import qdec_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  step_e            step_i,
    input  logic             clr_cnt_i,
    input  logic             clr_ovf_i,
    input  logic [CNT_W-1:0] lo_i,
    input  logic [CNT_W-1:0] hi_i,
    output logic [CNT_W-1:0] count_o,
    output qdec_stat_t       stat_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            count_o <= '0;
            stat_o  <= '0;
        end else begin
            if (clr_ovf_i) stat_o.ovf <= 1'b0;
            if (clr_cnt_i) begin
                count_o <= lo_i;
            end else if (step_i == STEP_UP) begin
                stat_o.dir <= 1'b1;
                if (count_o == hi_i) begin
                    count_o    <= lo_i;
                    stat_o.ovf <= 1'b1;
                    stat_o.top <= 1'b1;
                end else begin
                    count_o <= count_o + ONE;
                end
            end else if (step_i == STEP_DOWN) begin
                stat_o.dir <= 1'b0;
                if (count_o == lo_i) begin
                    count_o    <= hi_i;
                    stat_o.ovf <= 1'b1;
                    stat_o.top <= 1'b0;
                end else begin
                    count_o <= count_o - ONE;
                end
            end
        end
    end
endmodule

// File: rtl/qdec_top.sv
module qdec_top
    import qdec_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int FILT_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enc_a_i,
    input  logic              enc_b_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [CNT_W-1:0]  wr_data_i,
    output logic [CNT_W-1:0]  rd_data_o,
    output logic [CNT_W-1:0]  count_o,
    output logic              dir_o,
    output logic              ovf_o,
    output logic              ovf_top_o
);
    localparam int NUM_IN = 2;
    localparam logic [CNT_W-1:0] CTRL_MASK =
        CNT_W'((64'd1 << (CB_FVAL + NUM_IN * FILT_W)) - 64'd1) & ~CNT_W'(32'hE0);

    logic [CNT_W-1:0]  ctrl_q, lo_q, hi_q;
    logic              clr_cnt, clr_ovf;
    logic [NUM_IN-1:0] pin_w, lvl_w;
    step_e             step_w;
    qdec_stat_t        stat_w;

    assign clr_cnt = wr_en_i && (addr_i == ADR_CMD) && wr_data_i[0];
    assign clr_ovf = wr_en_i && (addr_i == ADR_CMD) && wr_data_i[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            lo_q   <= '0;
            hi_q   <= '1;
        end else if (wr_en_i) begin
            case (addr_i)
                ADR_CTRL: ctrl_q <= wr_data_i & CTRL_MASK;
                ADR_LOW:  lo_q   <= wr_data_i;
                ADR_HIGH: hi_q   <= wr_data_i;
                default:  ;
            endcase
        end
    end

    // index 1 = A, index 0 = B
    assign pin_w = {enc_a_i, enc_b_i};

    for (genvar gi = 0; gi < NUM_IN; gi++) begin : g_in
        localparam int SEL = NUM_IN - 1 - gi;   // 0 for A, 1 for B in the control word
        qdec_filter #(.FILT_W(FILT_W)) u_filt (
            .clk   (clk),
            .rst   (rst),
            .pin_i (pin_w[gi]),
            .inv_i (ctrl_q[CB_INV + SEL]),
            .en_i  (ctrl_q[CB_FEN + SEL]),
            .len_i (ctrl_q[CB_FVAL + SEL*FILT_W +: FILT_W]),
            .lvl_o (lvl_w[gi])
        );
    end

    qdec_decode u_dec (
        .clk           (clk),
        .rst           (rst),
        .strobe_mode_i (ctrl_q[CB_MODE]),
        .a_i           (lvl_w[1]),
        .b_i           (lvl_w[0]),
        .step_o        (step_w)
    );

    qdec_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .step_i    (step_w),
        .clr_cnt_i (clr_cnt),
        .clr_ovf_i (clr_ovf),
        .lo_i      (lo_q),
        .hi_i      (hi_q),
        .count_o   (count_o),
        .stat_o    (stat_w)
    );

    assign dir_o     = stat_w.dir;
    assign ovf_o     = stat_w.ovf;
    assign ovf_top_o = stat_w.top;

    always_comb begin
        case (addr_i)
            ADR_CTRL:  rd_data_o = ctrl_q;
            ADR_LOW:   rd_data_o = lo_q;
            ADR_HIGH:  rd_data_o = hi_q;
            ADR_CMD:   rd_data_o = CNT_W'(stat_w);
            ADR_COUNT: rd_data_o = count_o;
            default:   rd_data_o = '0;
        endcase
    end
endmodule

// File: rtl/qdec_checker.sv
module qdec_checker
    import qdec_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input step_e            step,
    input logic             clr_cnt,
    input logic             clr_ovf,
    input logic [CNT_W-1:0] lo,
    input logic [CNT_W-1:0] hi,
    input logic [CNT_W-1:0] count,
    input logic             dir,
    input logic             ovf,
    input logic             ovf_top
);
    AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (rst)
        (step == STEP_NONE && !clr_cnt) |=> $stable(count)); // R2

    AST_WRAP_TOP: assert property (@(posedge clk) disable iff (rst)
        (step == STEP_UP && count == hi && !clr_cnt) |=> (count == $past(lo) && ovf && ovf_top)); // R8

    AST_WRAP_BOTTOM: assert property (@(posedge clk) disable iff (rst)
        (step == STEP_DOWN && count == lo && count != hi && !clr_cnt)
        |=> (count == $past(hi) && ovf && !ovf_top)); // R9

    AST_DIR_UP: assert property (@(posedge clk) disable iff (rst)
        (step == STEP_UP && !clr_cnt) |=> dir); // R10

    AST_DIR_DOWN: assert property (@(posedge clk) disable iff (rst)
        (step == STEP_DOWN && !clr_cnt) |=> !dir); // R10

    AST_CLEAR_LOADS_LOW: assert property (@(posedge clk) disable iff (rst)
        clr_cnt |=> count == $past(lo)); // R11

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        (ovf && !clr_ovf) |=> ovf); // R12
endmodule

bind qdec_top qdec_checker #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .step    (step_w),
    .clr_cnt (clr_cnt),
    .clr_ovf (clr_ovf),
    .lo      (lo_q),
    .hi      (hi_q),
    .count   (count_o),
    .dir     (dir_o),
    .ovf     (ovf_o),
    .ovf_top (ovf_top_o)
);

// File: tb/qdec_top_tb.sv
module qdec_top_tb;
    localparam int CNT_W = 16;

    typedef struct {
        string            req;
        logic [CNT_W-1:0] cnt;
        logic             dir;
        logic             ovf;
        logic             top;
    } sb_item_t;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             enc_a = 1'b0, enc_b = 1'b0;
    logic             wr_en = 1'b0;
    logic [2:0]       addr = 3'd0;
    logic [CNT_W-1:0] wr_data = '0;
    logic [CNT_W-1:0] rd_data, count;
    logic             dir, ovf, ovf_top;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    sb_item_t sb_q[$];

    always #2.5 clk = ~clk;

    qdec_top #(.CNT_W(CNT_W), .FILT_W(4)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .enc_a_i   (enc_a),
        .enc_b_i   (enc_b),
        .wr_en_i   (wr_en),
        .addr_i    (addr),
        .wr_data_i (wr_data),
        .rd_data_o (rd_data),
        .count_o   (count),
        .dir_o     (dir),
        .ovf_o     (ovf),
        .ovf_top_o (ovf_top)
    );

    function automatic void check(string req, string what, logic [CNT_W-1:0] act, logic [CNT_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endfunction

    // monitor: pops expectations and compares against the ports
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                sb_item_t it;
                it = sb_q.pop_front();
                check(it.req, "count", count, it.cnt);
                check(it.req, "dir", CNT_W'(dir), CNT_W'(it.dir));
                check(it.req, "ovf", CNT_W'(ovf), CNT_W'(it.ovf));
                check(it.req, "ovf_top", CNT_W'(ovf_top), CNT_W'(it.top));
            end
        end
    end

    task automatic expect_state(string req, int c, bit d, bit o, bit t);
        sb_item_t it;
        it.req = req; it.cnt = CNT_W'(c); it.dir = d; it.ovf = o; it.top = t;
        sb_q.push_back(it);
        wait (sb_q.size() == 0);
    endtask

    task automatic ticks(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [2:0] a, int d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = CNT_W'(d);
        @(negedge clk);
        wr_en = 1'b0; addr = 3'd0; wr_data = '0;
        ticks(2);
    endtask

    task automatic rd_check(string req, logic [2:0] a, int exp);
        @(negedge clk);
        addr = a;
        #1;
        check(req, "read", rd_data, CNT_W'(exp));
        addr = 3'd0;
    endtask

    task automatic pins(bit a, bit b, int settle);
        @(negedge clk);
        enc_a = a; enc_b = b;
        ticks(settle);
    endtask

    task automatic pulse_a(int len, int settle);
        @(negedge clk);
        enc_a = 1'b1;
        ticks(len);
        enc_a = 1'b0;
        ticks(settle);
    endtask

    initial begin
        int wd = 0;
        while (!done && wd < 100000) begin
            @(posedge clk);
            wd++;
        end
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        ticks(4);
        rst = 1'b0;
        ticks(2);
        // R1 reset state
        expect_state("R1", 0, 0, 0, 0);
        rd_check("R1", 3'd1, 0);
        rd_check("R1", 3'd2, 16'hFFFF);

        // R11 clear loads low limit
        wr(3'd1, 10);
        wr(3'd2, 13);
        wr(3'd3, 1);
        expect_state("R11", 10, 0, 0, 0);

        // R2 up through the Gray order, R8 wrap at the top
        pins(1, 0, 8); expect_state("R2", 11, 1, 0, 0);
        pins(1, 1, 8); expect_state("R2", 12, 1, 0, 0);
        pins(0, 1, 8); expect_state("R2", 13, 1, 0, 0);
        pins(0, 0, 8); expect_state("R8", 10, 1, 1, 1);

        // R12 sticky, then cleared
        ticks(20); expect_state("R12", 10, 1, 1, 1);
        wr(3'd3, 2); expect_state("R12", 10, 1, 0, 1);

        // R9 wrap at the bottom, R10 direction
        pins(0, 1, 8); expect_state("R9", 13, 0, 1, 0);
        pins(1, 1, 8); expect_state("R10", 12, 0, 1, 0);

        // R3 double change ignored
        pins(0, 0, 8); expect_state("R3", 12, 0, 1, 0);
        pins(1, 0, 8); expect_state("R2", 13, 1, 1, 0);

        // R5 inversion
        wr(3'd2, 100);
        wr(3'd0, 16'h0002); expect_state("R5", 12, 0, 1, 0);
        pins(0, 0, 8);      expect_state("R5", 13, 1, 1, 0);
        wr(3'd0, 16'h0000); expect_state("R5", 12, 0, 1, 0);

        // R4 strobe and direction mode
        wr(3'd0, 16'h0001);
        pins(0, 1, 8); expect_state("R4", 12, 0, 1, 0);
        pins(1, 1, 8); expect_state("R4", 13, 1, 1, 0);
        pins(0, 1, 8); expect_state("R4", 13, 1, 1, 0);
        pins(0, 0, 8);
        pins(1, 0, 8); expect_state("R4", 12, 0, 1, 0);
        pins(0, 0, 8); expect_state("R4", 12, 0, 1, 0);

        // R6 filter length 6 on A
        wr(3'd0, 16'h0609);
        pins(0, 1, 8);
        pulse_a(3, 16); expect_state("R6", 12, 0, 1, 0);
        pins(1, 1, 16); expect_state("R6", 13, 1, 1, 0);
        pins(0, 1, 16); expect_state("R6", 13, 1, 1, 0);

        // R7 filter enabled with zero length, then filter disabled
        wr(3'd0, 16'h0009);
        pulse_a(1, 8); expect_state("R7", 14, 1, 1, 0);
        wr(3'd0, 16'h0601);
        pulse_a(1, 8); expect_state("R7", 15, 1, 1, 0);

        // R13 read-back
        rd_check("R13", 3'd0, 16'h0601);
        rd_check("R13", 3'd1, 10);
        rd_check("R13", 3'd2, 100);
        rd_check("R13", 3'd3, 3);
        rd_check("R13", 3'd4, 15);

        // R11 clear again from mid-range
        wr(3'd3, 1); expect_state("R11", 10, 1, 1, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule